// File: doc/BRIEF.md
# Monitor Load-Detect Sequencer

This block finds out whether an analog monitor loads a video DAC output. It does so by driving a fixed sequence of register writes on the DAC's control registers. A one-cycle `start` pulse makes it take a snapshot of the output-control and test-control registers through their read ports. It then forces a known configuration. After a settle wait it turns the output stage on, writes a test word that places the same mid-scale code on all three colour channels, and enables the comparator test. After a second settle wait it samples the comparator status, which appears as one bit of the test-control read value. It then turns the test off and writes both snapshots back.

The host sees a one-cycle `done` pulse and a `present` flag. The flag keeps its value until the next accepted start. Each settle wait lasts `SETTLE_CYCLES` clock cycles, and the default value gives 1 ms at 125 MHz. The block never writes two registers in the same cycle. It ignores `start` while a sequence is running.

Top module: `ldSequencer`

## Requirements
- R1: At the end of a sequence, the last write to the output-control register carries the exact value read from it at start, and the last write to test-control carries the exact value read from it at start.
- R2: The first write of a sequence goes to test-control and carries the saved value with bit 16 cleared and all other bits unchanged.
- R3: The second write goes to output-control and carries the saved value ANDed with 0x0000FFEE. When `secondary` is 1 the mask is 0x0000FEEE instead.
- R4: The third write goes to output-control and sets bit 0 of the masked value. It comes exactly `SETTLE_CYCLES`+1 cycles after the masking write.
- R5: The fourth write goes to the test-data register and carries 0x94050140. This is mode 2 in bits 31:30 and code 0x140 in each 10-bit channel field at bits 29:20, 19:10 and 9:0.
- R6: The fifth write sets bit 12 of test-control on top of its current read value. The comparator is sampled `SETTLE_CYCLES` cycles later, and the next write comes exactly `SETTLE_CYCLES`+2 cycles after the fifth.
- R7: `present` equals bit 28 of the test-control read value at sample time. The sixth write clears bit 12 of the current test-control read value, and it comes before both restore writes.
- R8: `done` is high for exactly one cycle per sequence, one cycle after the final restore write. `present` does not change from then until the next accepted `start`, whatever the comparator does.
- R9: A `start` pulse that arrives while a sequence is running is ignored. The sequence still makes exactly 8 writes and gives exactly one `done`.
- R10: After reset, `done` and `present` are 0 and no write enable is asserted.
- R11: At most one of the three write enables is high in any cycle. A sequence makes exactly 8 writes, in the order test-control, output-control, output-control, test-data, test-control, test-control, output-control, test-control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run a detection |
| secondary | input | 1 | Selects the narrower output mask for the second head |
| outCtlRd | input | 32 | Current output-control register value |
| testCtlRd | input | 32 | Current test-control register value; bit 28 is comparator status |
| outCtlWe | output | 1 | Output-control write strobe |
| outCtlWdata | output | 32 | Output-control write value |
| testCtlWe | output | 1 | Test-control write strobe |
| testCtlWdata | output | 32 | Test-control write value |
| testDataWe | output | 1 | Test-data write strobe |
| testDataWdata | output | 32 | Test-data write value |
| done | output | 1 | One-cycle end-of-sequence pulse |
| present | output | 1 | Monitor detected in the last sequence |

## Verification
The bench models the three registers and makes the comparator report a load only while bit 12 of test-control is set and a monitor is attached. This separates a correctly enabled test from a status bit that is read too early or left unset. It runs the sequence with all-ones and mixed snapshots, with and without a load, on both heads. The all-ones snapshot shows every bit that either mask clears, and the mixed snapshots show whether a restore puts back the original bits rather than a constant. Further runs send extra start pulses during both waits, and toggle the comparator after completion. These tell an ignored request from a restarted sequence, and a held result from one that follows the comparator.

// File: rtl/ldPkg.sv
package ldPkg;

  // Bit positions that the DAC decodes
  localparam int GATE_BIT    = 16;
  localparam int OUT_ON_BIT  = 0;
  localparam int TEST_ON_BIT = 12;
  localparam int SENSE_BIT   = 28;

  localparam logic [31:0] MASK_PRIMARY   = 32'h0000_FFEE;
  localparam logic [31:0] MASK_SECONDARY = 32'h0000_FEEE;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SAVE, ST_GATE, ST_MASK, ST_WAIT1, ST_OUTON, ST_TDATA,
    ST_TESTON, ST_WAIT2, ST_SAMPLE, ST_TESTOFF, ST_RSTOUT, ST_RSTTEST
  } ldStateT;

  typedef struct packed {
    logic capture;
    logic clearPresent;
    logic wrGate;
    logic wrMask;
    logic wrOutOn;
    logic wrTData;
    logic wrTestOn;
    logic doSample;
    logic wrTestOff;
    logic wrRestOut;
    logic wrRestTest;
  } ldStrobeT;

endpackage

// File: rtl/ldCtrl.sv
module ldCtrl
  import ldPkg::*;
#(
  parameter int SETTLE_CYCLES = 125000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output ldStrobeT strb,
  output logic     done
);

  localparam int TW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [TW-1:0] LAST_TICK = TW'(SETTLE_CYCLES - 1);

  ldStateT stateQ, stateD;
  logic [TW-1:0] timerQ;
  logic waiting;
  logic waitEnd;
  logic doneQ;

  assign waiting = (stateQ == ST_WAIT1) || (stateQ == ST_WAIT2);
  assign waitEnd = waiting && (timerQ == LAST_TICK);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (start) stateD = ST_SAVE;
      ST_SAVE:    stateD = ST_GATE;
      ST_GATE:    stateD = ST_MASK;
      ST_MASK:    stateD = ST_WAIT1;
      ST_WAIT1:   if (waitEnd) stateD = ST_OUTON;
      ST_OUTON:   stateD = ST_TDATA;
      ST_TDATA:   stateD = ST_TESTON;
      ST_TESTON:  stateD = ST_WAIT2;
      ST_WAIT2:   if (waitEnd) stateD = ST_SAMPLE;
      ST_SAMPLE:  stateD = ST_TESTOFF;
      ST_TESTOFF: stateD = ST_RSTOUT;
      ST_RSTOUT:  stateD = ST_RSTTEST;
      ST_RSTTEST: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      timerQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      timerQ <= (waiting && !waitEnd) ? timerQ + 1'b1 : '0;
      doneQ  <= (stateQ == ST_RSTTEST);
    end
  end

  always_comb begin
    strb              = '0;
    strb.capture      = (stateQ == ST_SAVE);
    strb.clearPresent = (stateQ == ST_SAVE);
    strb.wrGate       = (stateQ == ST_GATE);
    strb.wrMask       = (stateQ == ST_MASK);
    strb.wrOutOn      = (stateQ == ST_OUTON);
    strb.wrTData      = (stateQ == ST_TDATA);
    strb.wrTestOn     = (stateQ == ST_TESTON);
    strb.doSample     = (stateQ == ST_SAMPLE);
    strb.wrTestOff    = (stateQ == ST_TESTOFF);
    strb.wrRestOut    = (stateQ == ST_RSTOUT);
    strb.wrRestTest   = (stateQ == ST_RSTTEST);
  end

  assign done = doneQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R4
  settle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OUTON) |-> ($past(stateQ) == ST_WAIT1 && $past(timerQ) == LAST_TICK));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && start) |=> (stateQ != ST_SAVE));

endmodule

// File: rtl/ldData.sv
module ldData
  import ldPkg::*;
#(
  parameter int REG_W      = 32,
  parameter int CHAN_W     = 10,
  parameter int CHAN_COUNT = 3,
  parameter int MODE_W     = 2,
  parameter int TEST_MODE  = 2,
  parameter int TEST_LEVEL = 320
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secondary,
  input  ldStrobeT         strb,
  input  logic [REG_W-1:0] outCtlRd,
  input  logic [REG_W-1:0] testCtlRd,
  output logic             outCtlWe,
  output logic [REG_W-1:0] outCtlWdata,
  output logic             testCtlWe,
  output logic [REG_W-1:0] testCtlWdata,
  output logic             testDataWe,
  output logic [REG_W-1:0] testDataWdata,
  output logic             present
);

  localparam int WORD_W = MODE_W + CHAN_COUNT * CHAN_W;
  localparam logic [REG_W-1:0] GATE_M    = REG_W'(1) << GATE_BIT;
  localparam logic [REG_W-1:0] OUT_ON_M  = REG_W'(1) << OUT_ON_BIT;
  localparam logic [REG_W-1:0] TEST_ON_M = REG_W'(1) << TEST_ON_BIT;

  logic [REG_W-1:0] outSaveQ;
  logic [REG_W-1:0] testSaveQ;
  logic [REG_W-1:0] activeMask;
  logic [WORD_W-1:0] testWord;
  logic presentQ;

  for (genvar c = 0; c < CHAN_COUNT; c++) begin : gChan
    assign testWord[c*CHAN_W +: CHAN_W] = CHAN_W'(TEST_LEVEL);
  end
  assign testWord[WORD_W-1 -: MODE_W] = MODE_W'(TEST_MODE);

  assign activeMask = secondary ? REG_W'(MASK_SECONDARY) : REG_W'(MASK_PRIMARY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSaveQ  <= '0;
      testSaveQ <= '0;
      presentQ  <= 1'b0;
    end else begin
      if (strb.capture) begin
        outSaveQ  <= outCtlRd;
        testSaveQ <= testCtlRd;
      end
      if (strb.clearPresent)
        presentQ <= 1'b0;
      else if (strb.doSample)
        presentQ <= testCtlRd[SENSE_BIT];
    end
  end

  always_comb begin
    outCtlWe    = strb.wrMask | strb.wrOutOn | strb.wrRestOut;
    outCtlWdata = '0;
    if (strb.wrMask)         outCtlWdata = outSaveQ & activeMask;
    else if (strb.wrOutOn)   outCtlWdata = outCtlRd | OUT_ON_M;
    else if (strb.wrRestOut) outCtlWdata = outSaveQ;
  end

  always_comb begin
    testCtlWe    = strb.wrGate | strb.wrTestOn | strb.wrTestOff | strb.wrRestTest;
    testCtlWdata = '0;
    if (strb.wrGate)          testCtlWdata = testSaveQ & ~GATE_M;
    else if (strb.wrTestOn)   testCtlWdata = testCtlRd | TEST_ON_M;
    else if (strb.wrTestOff)  testCtlWdata = testCtlRd & ~TEST_ON_M;
    else if (strb.wrRestTest) testCtlWdata = testSaveQ;
  end

  assign testDataWe    = strb.wrTData;
  assign testDataWdata = REG_W'(testWord);
  assign present       = presentQ;

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outCtlWe, testCtlWe, testDataWe}));

  // R8
  present_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doSample && !strb.clearPresent) |=> $stable(presentQ));

  // R3
  mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |-> ((outCtlWdata & ~activeMask) == '0));

endmodule

// File: rtl/ldSequencer.sv
module ldSequencer
  import ldPkg::*;
#(
  parameter int REG_W         = 32,
  parameter int SETTLE_CYCLES = 125000,
  parameter int CHAN_W        = 10,
  parameter int CHAN_COUNT    = 3,
  parameter int TEST_LEVEL    = 320
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             secondary,
  input  logic [REG_W-1:0] outCtlRd,
  input  logic [REG_W-1:0] testCtlRd,
  output logic             outCtlWe,
  output logic [REG_W-1:0] outCtlWdata,
  output logic             testCtlWe,
  output logic [REG_W-1:0] testCtlWdata,
  output logic             testDataWe,
  output logic [REG_W-1:0] testDataWdata,
  output logic             done,
  output logic             present
);

  ldStrobeT strb;

  ldCtrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  ldData #(
    .REG_W      (REG_W),
    .CHAN_W     (CHAN_W),
    .CHAN_COUNT (CHAN_COUNT),
    .MODE_W     (2),
    .TEST_MODE  (2),
    .TEST_LEVEL (TEST_LEVEL)
  ) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .secondary     (secondary),
    .strb          (strb),
    .outCtlRd      (outCtlRd),
    .testCtlRd     (testCtlRd),
    .outCtlWe      (outCtlWe),
    .outCtlWdata   (outCtlWdata),
    .testCtlWe     (testCtlWe),
    .testCtlWdata  (testCtlWdata),
    .testDataWe    (testDataWe),
    .testDataWdata (testDataWdata),
    .present       (present)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!done && !present && !outCtlWe && !testCtlWe && !testDataWe));

endmodule

// File: tb/test_ldSequencer.sv
module test_ldSequencer;

  localparam int S = 16;
  localparam logic [31:0] B12 = 32'h0000_1000;
  localparam logic [31:0] B16 = 32'h0001_0000;
  localparam logic [31:0] B28 = 32'h1000_0000;
  localparam logic [31:0] TWORD = 32'h9405_0140;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic secondary = 1'b0;
  logic [31:0] outCtlRd, testCtlRd;
  logic outCtlWe, testCtlWe, testDataWe;
  logic [31:0] outCtlWdata, testCtlWdata, testDataWdata;
  logic done, present;

  logic [31:0] outReg = '0, tcReg = '0, tdReg = '0;
  logic monitorOn = 1'b0;

  int checks = 0, errors = 0, cycleCnt = 0;
  int doneCount = 0, doneLong = 0;
  logic prevDone = 1'b0;
  int logKind [32];
  logic [31:0] logData [32];
  int logCyc [32];
  int logN = 0;

  always #4 clk = ~clk;

  ldSequencer #(.SETTLE_CYCLES(S)) i_ldSequencer (
    .clk(clk), .rstN(rstN), .start(start), .secondary(secondary),
    .outCtlRd(outCtlRd), .testCtlRd(testCtlRd),
    .outCtlWe(outCtlWe), .outCtlWdata(outCtlWdata),
    .testCtlWe(testCtlWe), .testCtlWdata(testCtlWdata),
    .testDataWe(testDataWe), .testDataWdata(testDataWdata),
    .done(done), .present(present)
  );

  // Register model: comparator reports a load only while the test is on
  assign outCtlRd  = outReg;
  assign testCtlRd = {tcReg[31:29], monitorOn & tcReg[12], tcReg[27:0]};

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (outCtlWe)   outReg <= outCtlWdata;
    if (testCtlWe)  tcReg  <= testCtlWdata;
    if (testDataWe) tdReg  <= testDataWdata;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (outCtlWe || testCtlWe || testDataWe) begin
        if (logN < 32) begin
          logKind[logN] = outCtlWe ? 0 : (testCtlWe ? 1 : 2);
          logData[logN] = outCtlWe ? outCtlWdata : (testCtlWe ? testCtlWdata : testDataWdata);
          logCyc[logN]  = cycleCnt;
        end
        logN = logN + 1;
      end
      if (done) doneCount = doneCount + 1;
      if (done && prevDone) doneLong = doneLong + 1;
      prevDone = done;
    end
  end

  always @(posedge clk) begin
    if (cycleCnt == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Runs one sequence and checks the write trace against the requirements
  task automatic runSeq(input logic [31:0] iOut, input logic [31:0] iTcIn,
                        input logic sec, input logic load, input logic extra);
    logic [31:0] rb0, mask, gated;
    int waited;
    rb0 = iTcIn & ~(B12 | B28);
    mask = sec ? 32'h0000_FEEE : 32'h0000_FFEE;
    gated = rb0 & ~B16;
    @(negedge clk);
    outReg = iOut; tcReg = rb0; secondary = sec; monitorOn = load;
    logN = 0; doneCount = 0; doneLong = 0;
    pulseStart();
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (S + 4) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 1000) begin @(negedge clk); waited++; end
    repeat (4) @(negedge clk);
    check("R9 done count", doneCount, 1);
    check("R8 done width", doneLong, 0);
    check("R11 write count", logN, 8);
    if (logN >= 8) begin
      check("R11 kind0", logKind[0], 1);
      check("R2 gate write", logData[0], gated);
      check("R11 kind1", logKind[1], 0);
      check("R3 mask write", logData[1], iOut & mask);
      check("R11 kind2", logKind[2], 0);
      check("R4 output on", logData[2], (iOut & mask) | 32'h1);
      check("R4 settle gap", logCyc[2] - logCyc[1], S + 1);
      check("R11 kind3", logKind[3], 2);
      check("R5 test word", logData[3], TWORD);
      check("R11 kind4", logKind[4], 1);
      check("R6 test on", logData[4], gated | B12);
      check("R6 sample gap", logCyc[5] - logCyc[4], S + 2);
      check("R11 kind5", logKind[5], 1);
      check("R7 test off", logData[5], gated | (load ? B28 : 32'h0));
      check("R11 kind6", logKind[6], 0);
      check("R1 restore output", logData[6], iOut);
      check("R11 kind7", logKind[7], 1);
      check("R1 restore test", logData[7], rb0);
    end
    check("R1 final output reg", outReg, iOut);
    check("R1 final test reg", tcReg, rb0);
    check("R7 present", {31'b0, present}, {31'b0, load});
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R10 done", {31'b0, done}, 32'h0);
    check("R10 present", {31'b0, present}, 32'h0);
    check("R10 write enables", {29'b0, outCtlWe, testCtlWe, testDataWe}, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no writes", logN, 0);
    check("R10 present idle", {31'b0, present}, 32'h0);
  endtask

  task automatic testPrimaryLoad();  runSeq(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0); endtask
  task automatic testPrimaryEmpty(); runSeq(32'h1234_5679, 32'h8765_4321, 1'b0, 1'b0, 1'b0); endtask
  task automatic testSecondaryLoad(); runSeq(32'hFFFF_FFFF, 32'h0001_0000, 1'b1, 1'b1, 1'b0); endtask
  task automatic testSecondaryEmpty(); runSeq(32'hA5A5_0111, 32'h5A5A_A5A5, 1'b1, 1'b0, 1'b0); endtask
  task automatic testBusyStart();    runSeq(32'h0000_0F0F, 32'h0F0F_0000, 1'b0, 1'b1, 1'b1); endtask

  task automatic testPresentHold();
    logic first;
    runSeq(32'h0000_00FF, 32'h0000_00FF, 1'b0, 1'b1, 1'b0);
    first = present;
    @(negedge clk);
    tcReg = tcReg | B12; monitorOn = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 present hold low comparator", {31'b0, present}, {31'b0, first});
    monitorOn = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 present hold high comparator", {31'b0, present}, {31'b0, first});
    tcReg = tcReg & ~B12;
    runSeq(32'h0000_00FF, 32'h0000_00FF, 1'b0, 1'b0, 1'b0);
    check("R8 present after restart", {31'b0, present}, 32'h0);
  endtask

  initial begin
    testReset();
    testPrimaryLoad();
    testPrimaryEmpty();
    testSecondaryLoad();
    testSecondaryEmpty();
    testBusyStart();
    testPresentHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule